// File: doc/BRIEF.md
# Event Timer Comparator Channel

This block is one comparator channel of a multi-channel event timer. A free-running 64-bit main counter sits outside the block and is shared by all channels. The channel compares that counter with its own comparator. When the counter reaches the comparator, the channel emits a one-cycle match strobe toward the interrupt logic. It can run in one-shot mode or in periodic mode. In periodic mode a hidden period register is added to the comparator after every match. A narrow mode restricts the channel to the low 32 bits of the counter. In narrow one-shot mode the channel also strobes a wrap output when the low counter word rolls over before the match occurs.

Software reaches the channel through a 32-bit write port with three targets: the configuration word, the low comparator word and the high comparator word. While the channel is periodic, a one-time "load now" bit decides what a comparator write does. If the bit is set, the write loads the visible comparator as well as the period. If the bit is clear, the write updates only the period. The comparator value and the configuration bits are brought out so that the surrounding register block can read them back.

Top module: `evt_timer_channel`

## Requirements
- R1: After reset `cfg_o` is 0, `cmp_o` is all ones, and `match_o` and `wrap_o` are 0.
- R2: Write target `wr_sel_i` encodings: 0 selects the configuration word, 1 the low comparator word, 2 the high comparator word, 3 nothing. A configuration write stores `wr_data_i[3:0]` into `cfg_o` on the next edge. Bit 0 is enable, bit 1 periodic, bit 2 load-now and bit 3 narrow.
- R3: In one-shot mode a comparator word write loads `cmp_o` directly. When the counter reaches the comparator, `match_o` pulses high for exactly one cycle, one cycle after the counter value is presented. It then stays low until the comparator is rewritten or the channel is re-armed, and `cmp_o` does not move.
- R4: The channel is armed one cycle after both the enable bit and `glb_en_i` are 1. While either is 0, no match is signalled.
- R5: In periodic mode with load-now clear, a comparator write leaves `cmp_o` unchanged and updates only the hidden period. With load-now set, the write updates both.
- R6: Any comparator word write clears the load-now bit.
- R7: On a periodic match, `cmp_o` advances by the period and one match pulse is emitted. If the counter is still at or past the new value, the channel adds one more period per cycle until the comparator is ahead, with no further pulses.
- R8: The top bit of a written period is dropped: bit 31 of the low word in narrow mode, bit 63 in wide mode.
- R9: Setting the narrow bit truncates the comparator and the period to their low 32 bits. In narrow mode only the low counter word is compared, a periodic advance wraps modulo 2^32, and high comparator writes are ignored.
- R10: In narrow one-shot mode, one `wrap_o` pulse is emitted when the low counter word rolls over before the match. The match still fires later.
- R11: "Reached" means the counter minus the comparator is non-negative as a signed value of the active width. A counter just below the wrap point therefore has not reached a small comparator.
- R12: In periodic mode with a period of zero, the channel fires once and does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnt_i | input | 64 | Shared main counter value |
| glb_en_i | input | 1 | Global timer enable |
| wr_en_i | input | 1 | Register write strobe |
| wr_sel_i | input | 2 | Write target: 0 config, 1 comparator low, 2 comparator high |
| wr_data_i | input | 32 | Write data |
| match_o | output | 1 | One-cycle match strobe |
| wrap_o | output | 1 | One-cycle narrow one-shot rollover strobe |
| cmp_o | output | 64 | Visible comparator value |
| cfg_o | output | 4 | Configuration bits {narrow, load-now, periodic, enable} |

## Verification
The checks assume that the counter input only moves forward while the channel is armed, modulo 2^64. Under that assumption, a decrease of the low word can only mean a rollover. The bench changes the counter to an unrelated value only while the channel is disarmed. While armed, it moves the counter only forward, sometimes by large steps, so that one edge covers a rollover or a catch-up. Writes are issued one per cycle and never target code 3. The assertions therefore see only the write patterns that the requirements define.

// File: rtl/evt_chan_pkg.sv
// Shared types for the event timer comparator channel.
// Assumes a 4-bit configuration field laid out as {narrow, load-now, periodic, enable}.
package evt_chan_pkg;

    typedef enum logic [1:0] {
        SEL_CFG    = 2'd0,
        SEL_CMP_LO = 2'd1,
        SEL_CMP_HI = 2'd2,
        SEL_IDLE   = 2'd3
    } wr_sel_e;

    localparam int CFG_W = 4;

    typedef struct packed {
        logic narrow;
        logic setv;
        logic per;
        logic en;
    } cfg_t;

endpackage

// File: rtl/evt_cmp_unit.sv
// Combinational compare and advance for one channel.
// Decides whether the counter has reached the comparator (signed difference,
// full or low-word width), forms comparator + period, and tells whether the
// counter is still at or past that sum. Assumes CNT_W > WORD_W.
module evt_cmp_unit #(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32
) (
    input  logic [CNT_W-1:0] cnt,
    input  logic [CNT_W-1:0] cmp,
    input  logic [CNT_W-1:0] period,
    input  logic             narrow,
    output logic             reached,
    output logic [CNT_W-1:0] next_cmp,
    output logic             next_reached
);
    localparam int PAD_W = CNT_W - WORD_W;

    logic [CNT_W-1:0]  d_full, sum_full, nd_full;
    logic [WORD_W-1:0] d_lo, sum_lo, nd_lo;

    // Differences and sums at both widths; the narrow flag picks one.
    always_comb begin
        d_full   = cnt - cmp;
        d_lo     = cnt[WORD_W-1:0] - cmp[WORD_W-1:0];
        sum_full = cmp + period;
        sum_lo   = cmp[WORD_W-1:0] + period[WORD_W-1:0];
        nd_full  = cnt - sum_full;
        nd_lo    = cnt[WORD_W-1:0] - sum_lo;
        if (narrow) begin
            reached      = ~d_lo[WORD_W-1];
            next_cmp     = {{PAD_W{1'b0}}, sum_lo};
            next_reached = ~nd_lo[WORD_W-1];
        end else begin
            reached      = ~d_full[CNT_W-1];
            next_cmp     = sum_full;
            next_reached = ~nd_full[CNT_W-1];
        end
    end

endmodule

// File: rtl/evt_wrap_det.sv
// Low-word rollover detector.
// Remembers the previous low counter word; a drop in value means the word
// wrapped past all ones. Assumes the counter never steps backward.
module evt_wrap_det #(
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [WORD_W-1:0] cnt_lo,
    output logic              roll
);
    logic [WORD_W-1:0] prev_lo;
    logic              prev_ok;

    // Track the last low word seen.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_lo <= '0;
            prev_ok <= 1'b0;
        end else begin
            prev_lo <= cnt_lo;
            prev_ok <= 1'b1;
        end
    end

    // Rollover is flagged when the word is smaller than last cycle.
    always_comb roll = prev_ok && (cnt_lo < prev_lo);

endmodule

// File: rtl/evt_chan_regs.sv
// Register file of one channel: configuration bits, visible comparator and
// hidden period. Steers comparator writes by mode and the load-now bit, masks
// the period's top bit and truncates on narrow mode. A write wins over an
// advance in the same cycle. Assumes CNT_W - WORD_W <= WORD_W.
module evt_chan_regs
    import evt_chan_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  wr_sel_e           wr_sel,
    input  logic [WORD_W-1:0] wr_data,
    input  logic              adv,
    input  logic [CNT_W-1:0]  adv_val,
    output cfg_t              cfg,
    output logic [CNT_W-1:0]  cmp,
    output logic [CNT_W-1:0]  period,
    output logic              cmp_wr
);
    localparam int HI_W  = CNT_W - WORD_W;

    logic load_cmp;

    // A comparator word write reaches the visible comparator in one-shot mode or with load-now.
    always_comb begin
        load_cmp = !cfg.per || cfg.setv;
        cmp_wr   = wr_en && (wr_sel == SEL_CMP_LO || wr_sel == SEL_CMP_HI);
    end

    // Update configuration, comparator and period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg    <= '0;
            cmp    <= '1;
            period <= '0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_CFG: begin
                    cfg <= cfg_t'(wr_data[CFG_W-1:0]);
                    if (wr_data[3]) begin
                        cmp    <= {{HI_W{1'b0}}, cmp[WORD_W-1:0]};
                        period <= {{HI_W{1'b0}}, period[WORD_W-1:0]};
                    end
                end
                SEL_CMP_LO: begin
                    if (load_cmp) cmp[WORD_W-1:0] <= wr_data;
                    if (cfg.per) begin
                        period[WORD_W-1:0] <= cfg.narrow ? {1'b0, wr_data[WORD_W-2:0]} : wr_data;
                    end
                    cfg.setv <= 1'b0;
                end
                SEL_CMP_HI: begin
                    if (!cfg.narrow) begin
                        if (load_cmp) cmp[CNT_W-1:WORD_W] <= wr_data[HI_W-1:0];
                        if (cfg.per) period[CNT_W-1:WORD_W] <= {1'b0, wr_data[HI_W-2:0]};
                    end
                    cfg.setv <= 1'b0;
                end
                default: ;
            endcase
        end else if (adv) begin
            cmp <= adv_val;
        end
    end

endmodule

// File: rtl/evt_timer_channel.sv
// One comparator channel of an event timer.
// Watches the shared counter, strobes match_o one cycle after the counter
// reaches the comparator, reloads from the period in periodic mode (one step
// per cycle while behind) and strobes wrap_o on a low-word rollover in narrow
// one-shot mode. Assumes cnt_i moves forward while the channel is armed.
module evt_timer_channel
    import evt_chan_pkg::*;
#(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CNT_W-1:0]  cnt_i,
    input  logic              glb_en_i,
    input  logic              wr_en_i,
    input  logic [1:0]        wr_sel_i,
    input  logic [WORD_W-1:0] wr_data_i,
    output logic              match_o,
    output logic              wrap_o,
    output logic [CNT_W-1:0]  cmp_o,
    output logic [CFG_W-1:0]  cfg_o
);
    cfg_t             cfg;
    logic [CNT_W-1:0] cmp, period, next_cmp;
    logic             reached, next_reached, roll, cmp_wr;
    logic             armed, fired, catch_up, wrap_watch;
    logic             arm_evt, period_live, hit, fire, adv, wrap_fire;

    evt_chan_regs #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en_i),
        .wr_sel  (wr_sel_e'(wr_sel_i)),
        .wr_data (wr_data_i),
        .adv     (adv),
        .adv_val (next_cmp),
        .cfg     (cfg),
        .cmp     (cmp),
        .period  (period),
        .cmp_wr  (cmp_wr)
    );

    evt_cmp_unit #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_cmp (
        .cnt          (cnt_i),
        .cmp          (cmp),
        .period       (period),
        .narrow       (cfg.narrow),
        .reached      (reached),
        .next_cmp     (next_cmp),
        .next_reached (next_reached)
    );

    evt_wrap_det #(.WORD_W(WORD_W)) u_wrap (
        .clk    (clk),
        .rst_n  (rst_n),
        .cnt_lo (cnt_i[WORD_W-1:0]),
        .roll   (roll)
    );

    // Decide this cycle's match, advance and wrap events.
    always_comb begin
        arm_evt     = cfg.en && glb_en_i && !armed;
        period_live = cfg.per && (period != '0);
        hit         = armed && reached && !fired && !cmp_wr;
        fire        = hit && !catch_up;
        adv         = hit && period_live;
        wrap_fire   = armed && cfg.narrow && !cfg.per && !fired && wrap_watch && roll && !cmp_wr;
    end

    // Arming state, one-shot latch, catch-up flag and output strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            armed      <= 1'b0;
            fired      <= 1'b0;
            catch_up   <= 1'b0;
            wrap_watch <= 1'b0;
            match_o    <= 1'b0;
            wrap_o     <= 1'b0;
        end else begin
            armed   <= cfg.en && glb_en_i;
            match_o <= fire;
            wrap_o  <= wrap_fire;
            if (cmp_wr || arm_evt) begin
                fired      <= 1'b0;
                catch_up   <= 1'b0;
                wrap_watch <= 1'b1;
            end else begin
                if (hit && !period_live) fired <= 1'b1;
                catch_up <= adv && next_reached;
                if (wrap_fire) wrap_watch <= 1'b0;
            end
        end
    end

    // Readback of the visible state.
    always_comb begin
        cmp_o = cmp;
        cfg_o = cfg;
    end

endmodule

// File: rtl/evt_chan_chk.sv
// Property checker for evt_timer_channel, attached through bind.
// Assumes the counter input does not step backward while the channel is armed.
module evt_chan_chk #(
    parameter int CNT_W  = 64,
    parameter int WORD_W = 32
) (
    input logic              clk,
    input logic              rst_n,
    input logic              glb_en_i,
    input logic              wr_en_i,
    input logic [1:0]        wr_sel_i,
    input logic [WORD_W-1:0] wr_data_i,
    input logic              match_o,
    input logic              wrap_o,
    input logic [CNT_W-1:0]  cmp_o,
    input logic [3:0]        cfg_o
);
    // R2: a config write lands in cfg_o on the next edge
    p_cfg_store_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && wr_sel_i == 2'd0) |=> (cfg_o == $past(wr_data_i[3:0])));

    // R4: a match needs enable and global enable two cycles earlier
    p_match_gate_r4: assert property (@(posedge clk) disable iff (!rst_n)
        match_o |-> ($past(glb_en_i, 2) && $past(cfg_o[0], 2)));

    // R6: any comparator word write clears load-now
    p_setv_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_i && (wr_sel_i == 2'd1 || wr_sel_i == 2'd2)) |=> !cfg_o[2]);

    // R9: narrow mode keeps the comparator's upper part at zero
    p_narrow_upper_r9: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_o[3] |-> (cmp_o[CNT_W-1:WORD_W] == '0));

    // R10: the wrap strobe only comes from narrow one-shot mode
    p_wrap_mode_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wrap_o |-> $past(cfg_o[3] && !cfg_o[1]));

endmodule

bind evt_timer_channel evt_chan_chk #(.CNT_W(CNT_W), .WORD_W(WORD_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .glb_en_i  (glb_en_i),
    .wr_en_i   (wr_en_i),
    .wr_sel_i  (wr_sel_i),
    .wr_data_i (wr_data_i),
    .match_o   (match_o),
    .wrap_o    (wrap_o),
    .cmp_o     (cmp_o),
    .cfg_o     (cfg_o)
);

// File: tb/tb_evt_timer_channel.sv
// Directed bench for evt_timer_channel: one task per scenario.
module tb_evt_timer_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] cnt_i = '0;
    logic        glb_en_i = 1'b0;
    logic        wr_en_i = 1'b0;
    logic [1:0]  wr_sel_i = 2'd3;
    logic [31:0] wr_data_i = '0;
    logic        match_o, wrap_o;
    logic [63:0] cmp_o;
    logic [3:0]  cfg_o;

    int n_chk = 0;
    int n_bad = 0;

    always #10 clk = ~clk;

    evt_timer_channel dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .cnt_i     (cnt_i),
        .glb_en_i  (glb_en_i),
        .wr_en_i   (wr_en_i),
        .wr_sel_i  (wr_sel_i),
        .wr_data_i (wr_data_i),
        .match_o   (match_o),
        .wrap_o    (wrap_o),
        .cmp_o     (cmp_o),
        .cfg_o     (cfg_o)
    );

    task automatic step();
        @(negedge clk);
    endtask

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] sel, input logic [31:0] data);
        wr_en_i = 1'b1; wr_sel_i = sel; wr_data_i = data;
        step();
        wr_en_i = 1'b0; wr_sel_i = 2'd3;
    endtask

    task automatic finish_run();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    // R1: reset values
    task automatic t_reset();
        chk("R1 cfg", 64'(cfg_o), 64'h0);
        chk("R1 cmp", cmp_o, '1);
        chk("R1 match", 64'(match_o), 0);
        chk("R1 wrap", 64'(wrap_o), 0);
    endtask

    // R2, R3: one-shot load, single pulse
    task automatic t_oneshot();
        glb_en_i = 1'b1; cnt_i = 64'd100;
        wr(2'd1, 32'd200); wr(2'd2, 32'd0);
        chk("R3 cmp load", cmp_o, 64'd200);
        wr(2'd0, 32'h1);
        chk("R2 cfg store", 64'(cfg_o), 64'h1);
        step();
        cnt_i = 64'd150; step();
        chk("R3 below", 64'(match_o), 0);
        cnt_i = 64'd200; step();
        chk("R3 pulse", 64'(match_o), 1);
        step();
        chk("R3 single", 64'(match_o), 0);
        cnt_i = 64'd300; step();
        chk("R3 no refire", 64'(match_o), 0);
        chk("R3 cmp still", cmp_o, 64'd200);
    endtask

    // R4: global enable gates, arming takes one cycle
    task automatic t_gating();
        glb_en_i = 1'b0;
        wr(2'd1, 32'd400);
        cnt_i = 64'd500;
        for (int i = 0; i < 3; i++) begin
            step();
            chk("R4 gated", 64'(match_o), 0);
        end
        glb_en_i = 1'b1;
        step();
        chk("R4 arm delay", 64'(match_o), 0);
        step();
        chk("R4 armed pulse", 64'(match_o), 1);
        wr(2'd0, 32'h0);
    endtask

    // R5, R6, R7: periodic steering, load-now clear, reload and catch-up
    task automatic t_periodic();
        wr(2'd0, 32'h6);
        chk("R2 cfg 6", 64'(cfg_o), 64'h6);
        wr(2'd1, 32'd1000);
        chk("R5 load-now cmp", cmp_o, 64'd1000);
        chk("R6 load-now cleared", 64'(cfg_o), 64'h2);
        wr(2'd2, 32'd0);
        wr(2'd1, 32'd250);
        chk("R5 period only", cmp_o, 64'd1000);
        cnt_i = 64'd900;
        wr(2'd0, 32'h3);
        step();
        cnt_i = 64'd1000; step();
        chk("R7 pulse", 64'(match_o), 1);
        chk("R7 advance", cmp_o, 64'd1250);
        step();
        chk("R7 single", 64'(match_o), 0);
        cnt_i = 64'd1250; step();
        chk("R7 second", 64'(match_o), 1);
        chk("R7 advance2", cmp_o, 64'd1500);
        cnt_i = 64'd2100; step();
        chk("R7 catch pulse", 64'(match_o), 1);
        chk("R7 catch c1", cmp_o, 64'd1750);
        step();
        chk("R7 catch quiet1", 64'(match_o), 0);
        chk("R7 catch c2", cmp_o, 64'd2000);
        step();
        chk("R7 catch quiet2", 64'(match_o), 0);
        chk("R7 catch c3", cmp_o, 64'd2250);
        step();
        chk("R7 ahead", cmp_o, 64'd2250);
        chk("R7 ahead quiet", 64'(match_o), 0);
    endtask

    // R8: period top bit dropped in wide mode
    task automatic t_mask();
        wr(2'd0, 32'h2);
        wr(2'd0, 32'h6); wr(2'd1, 32'd0);
        wr(2'd0, 32'h6); wr(2'd2, 32'd0);
        wr(2'd1, 32'h10); wr(2'd2, 32'hFFFF_FFFF);
        chk("R8 cmp zero", cmp_o, 64'd0);
        cnt_i = 64'd0;
        wr(2'd0, 32'h3);
        step(); step();
        chk("R8 pulse", 64'(match_o), 1);
        chk("R8 masked period", cmp_o, 64'h7FFF_FFFF_0000_0010);
        step();
        chk("R8 quiet", 64'(match_o), 0);
    endtask

    // R9: narrow truncation, ignored high write, modulo advance
    task automatic t_narrow();
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h5); wr(2'd2, 32'h1);
        chk("R9 wide cmp", cmp_o, 64'h1_0000_0005);
        wr(2'd0, 32'h8);
        chk("R9 truncate", cmp_o, 64'h5);
        wr(2'd2, 32'h3);
        chk("R9 hi ignored", cmp_o, 64'h5);
        wr(2'd0, 32'hE);
        wr(2'd1, 32'hFFFF_FFF0);
        chk("R9 narrow cfg", 64'(cfg_o), 64'hA);
        wr(2'd1, 32'h20);
        cnt_i = 64'h5_FFFF_FFE0;
        wr(2'd0, 32'hB);
        step();
        cnt_i = 64'h5_FFFF_FFF0; step();
        chk("R9 pulse", 64'(match_o), 1);
        chk("R9 wrap add", cmp_o, 64'h10);
        step();
        chk("R9 quiet", 64'(match_o), 0);
        cnt_i = 64'h6_0000_0010; step();
        chk("R9 next pulse", 64'(match_o), 1);
        chk("R9 next cmp", cmp_o, 64'h30);
        chk("R9 periodic no wrap", 64'(wrap_o), 0);
    endtask

    // R11: signed compare in wide mode
    task automatic t_signed();
        wr(2'd0, 32'h0);
        wr(2'd1, 32'h10); wr(2'd2, 32'h0);
        cnt_i = 64'hFFFF_FFFF_FFFF_FFF0;
        wr(2'd0, 32'h1);
        step(); step();
        chk("R11 not reached", 64'(match_o), 0);
        cnt_i = 64'h10; step();
        chk("R11 reached", 64'(match_o), 1);
        chk("R11 wide no wrap", 64'(wrap_o), 0);
    endtask

    // R10: narrow one-shot rollover strobe
    task automatic t_wrap();
        wr(2'd0, 32'h0);
        wr(2'd0, 32'h8);
        wr(2'd1, 32'h100);
        cnt_i = 64'hFFFF_FF00;
        wr(2'd0, 32'h9);
        step();
        cnt_i = 64'hFFFF_FFFF; step();
        chk("R10 before roll", 64'(wrap_o), 0);
        chk("R10 no match yet", 64'(match_o), 0);
        cnt_i = 64'h1_0000_0005; step();
        chk("R10 wrap pulse", 64'(wrap_o), 1);
        chk("R10 no match at roll", 64'(match_o), 0);
        step();
        chk("R10 single wrap", 64'(wrap_o), 0);
        cnt_i = 64'h1_0000_0100; step();
        chk("R10 match after wrap", 64'(match_o), 1);
        chk("R10 no second wrap", 64'(wrap_o), 0);
    endtask

    // R12: periodic with zero period fires once
    task automatic t_zero_period();
        wr(2'd0, 32'h0);
        wr(2'd0, 32'h6); wr(2'd1, 32'h500);
        wr(2'd0, 32'h6); wr(2'd2, 32'h0);
        wr(2'd1, 32'h0);
        cnt_i = 64'h400;
        wr(2'd0, 32'h3);
        step();
        cnt_i = 64'h500; step();
        chk("R12 pulse", 64'(match_o), 1);
        chk("R12 no advance", cmp_o, 64'h500);
        step();
        chk("R12 once a", 64'(match_o), 0);
        step();
        chk("R12 once b", 64'(match_o), 0);
    endtask

    initial begin
        repeat (3) step();
        rst_n = 1'b1;
        step();
        t_reset();
        t_oneshot();
        t_gating();
        t_periodic();
        t_mask();
        t_narrow();
        t_signed();
        t_wrap();
        t_zero_period();
        finish_run();
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        finish_run();
    end

endmodule